// File: doc/BRIEF.md
# Circular Sample Delay Line Address Generator

This block keeps the last N samples of a signal in a run of N memory words, for a FIR filter, without ever moving the stored data. One pointer marks the slot that the next sample fills. Each accepted sample is written there, overwriting the oldest entry, and the pointer then moves forward by one. After the last word of the window the pointer returns to the first word, so the two ends of the window act as neighbours. The block only produces addresses and write data for an external memory. The multiply-accumulate datapath lies outside it.

A filter pass is requested with a single-cycle start pulse. The block then produces N read addresses on a valid/ready stream. The first is the newest sample and each later one is one slot older, with the walk going backward across the window edge. The last address of the pass carries a done flag. The window length N does not have to be a power of two, and the wrap is found by comparing the address with the window's last word, not by masking. The base address must be aligned to the smallest power of two above N. A bad length or base raises an error flag and stops all writes and passes.

Sample input is a valid/ready stream. `smp_ready` drops while the configuration is bad or while the one-entry holding register is full. A sampled beat (`smp_valid` and `smp_ready` both high at a clock edge) is always taken, either into memory or into the holding register. The read stream waits on `rd_ready`: while it is low, the address stays put. Configuration is sampled continuously and must only change around a reset. After reset the pointer starts at the base.

Top module: `circ_delay_line`

## Requirements
- R1: After reset, `wr_en` and `rd_valid` are 0. With a valid configuration `smp_ready` is 1, and the first sample written goes to the base address.
- R2: Each sample that is written goes to the slot after the previous one. Every write address lies between base and base+N-1, and a write to base+N-1 is followed by a write to base.
- R3: `cfg_err` is 1 when N is 0, or when any of the low nb bits of the base is 1, where nb is the bit count of N written in binary (for example N=30 needs 5 zero bits, N=32 needs 6). While `cfg_err` is 1, `smp_ready` is 0, `wr_en` stays 0 and `pass_start` is ignored.
- R4: While no pass is active, an accepted sample is written in the same cycle: `wr_en` is 1 and `wr_data` equals `smp_data`.
- R5: A `pass_start` while idle makes `rd_valid` rise in the next cycle. The pass emits N addresses. The first is the most recently written slot, counting a sample written in the start cycle itself. Each following address is one slot older.
- R6: `pass_done` is 1 exactly with the last address of a pass. After that address is taken, `rd_valid` falls in the next cycle.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, `rd_addr` and `rd_valid` stay unchanged.
- R8: During a pass, one sample can be accepted into a holding register and is not written. `smp_ready` then stays 0 until that sample is written, which happens in the first cycle after the pass ends, to the next slot.
- R9: A `pass_start` while a pass is active has no effect: the running pass still ends after N addresses, and `rd_valid` falls after its last address.
- R10: The wrap works for any N, not only powers of two. Stepping back from base gives base+N-1, and stepping forward from base+N-1 gives base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | LEN_W | Window length N |
| cfg_base | input | ADDR_W | First word of the window |
| cfg_err | output | 1 | Length or base breaks the alignment rule |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_data | input | DATA_W | Sample value |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| pass_start | input | 1 | Pulse that starts a read pass |
| rd_valid | output | 1 | Read address stream valid |
| rd_ready | input | 1 | Read address stream ready |
| rd_addr | output | ADDR_W | Read address, newest to oldest |
| pass_done | output | 1 | Marks the final address of a pass |

## Verification
Writes are combinational with the sample handshake, so the bench drives each sample at the falling edge and checks `wr_en`, `wr_addr` and `wr_data` one time step later, in the same cycle. The read walk is registered: `rd_valid` is checked in the first cycle after the start pulse, and every later address in the cycle after the previous one is taken, or in the same cycle again after a stall. A sample held during a pass is checked in the single cycle right after the cycle that took the last read address. The bench sweeps several window lengths, powers of two and others, at aligned bases. For each it computes expected offsets by modular arithmetic on its own counter, and it checks the error flag against misaligned bases.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;
endpackage

// File: rtl/cdl_cfg_check.sv
module cdl_cfg_check #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  output logic              cfg_err,
  output logic [ADDR_W-1:0] last_addr
);
  logic [LEN_W-1:0]  smear;
  logic [ADDR_W-1:0] align_mask;

  // Fill every bit below the top set bit of len to build the low-bit mask.
  always_comb begin
    smear = len;
    for (int s = 0; s < LEN_W; s++) begin
      smear = smear | (smear >> 1);
    end
    align_mask = ADDR_W'(smear);
    cfg_err    = (len == '0) || ((base & align_mask) != '0);
    last_addr  = base + ADDR_W'(len) - ADDR_W'(1);
  end
endmodule

// File: rtl/cdl_wr_ctrl.sv
module cdl_wr_ctrl #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_err,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              walk_busy,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LEN_W-1:0]  newest_ofs
);
  logic [LEN_W-1:0]  wofs;
  logic [LEN_W-1:0]  wofs_nxt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              accept;
  logic              flush;
  logic              direct;
  logic              at_last;

  always_comb begin
    smp_ready = !cfg_err && !hold_full;
    accept    = smp_valid && smp_ready;
    flush     = hold_full && !walk_busy && !cfg_err;
    direct    = accept && !walk_busy;
    wr_en     = flush || direct;
    wr_data   = flush ? hold_data : smp_data;
    wr_addr   = base + ADDR_W'(wofs);
    at_last   = (wr_addr == last_addr);
    if (wr_en) begin
      wofs_nxt = at_last ? '0 : wofs + 1'b1;
    end else begin
      wofs_nxt = wofs;
    end
    newest_ofs = (wofs_nxt == '0) ? len - 1'b1 : wofs_nxt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wofs      <= '0;
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      wofs <= wofs_nxt;
      if (accept && walk_busy) begin
        hold_full <= 1'b1;
        hold_data <= smp_data;
      end else if (flush) begin
        hold_full <= 1'b0;
      end
    end
  end

  AST_ERR_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !wr_en); // R3
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr >= base && wr_addr <= last_addr)); // R2
  AST_WR_WRAPS_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == last_addr && !cfg_err) |=> (wr_addr == base)); // R10
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && walk_busy) |=> hold_full); // R8
  AST_HOLD_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(walk_busy) && hold_full && !cfg_err) |-> (wr_en && wr_data == hold_data)); // R8
endmodule

// File: rtl/cdl_rd_walk.sv
module cdl_rd_walk
  import cdl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_err,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [LEN_W-1:0]  newest_ofs,
  input  logic              pass_start,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pass_done
);
  walk_state_e      state;
  logic [LEN_W-1:0] rofs;
  logic [LEN_W-1:0] cnt;
  logic             fire;

  always_comb begin
    busy      = (state == WALK_BUSY);
    rd_valid  = busy;
    rd_addr   = base + ADDR_W'(rofs);
    pass_done = busy && (cnt == len - 1'b1);
    fire      = rd_valid && rd_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WALK_IDLE;
      rofs  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        WALK_IDLE: begin
          if (pass_start && !cfg_err) begin
            state <= WALK_BUSY;
            rofs  <= newest_ofs;
            cnt   <= '0;
          end
        end
        WALK_BUSY: begin
          if (fire) begin
            if (pass_done) begin
              state <= WALK_IDLE;
            end else begin
              cnt  <= cnt + 1'b1;
              rofs <= (rd_addr == base) ? len - 1'b1 : rofs - 1'b1;
            end
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr >= base && rd_addr <= last_addr)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && pass_done) |=> !rd_valid); // R6
  AST_STEP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !pass_done && rd_addr != base)
      |=> (rd_addr == $past(rd_addr) - ADDR_W'(1))); // R5
  AST_BACK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !pass_done && rd_addr == base)
      |=> (rd_addr == last_addr)); // R10
  AST_ERR_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !rd_valid) |=> !rd_valid); // R3
endmodule

// File: rtl/circ_delay_line.sv
module circ_delay_line #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              cfg_err,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              pass_start,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pass_done
);
  logic [ADDR_W-1:0] last_addr;
  logic [LEN_W-1:0]  newest_ofs;
  logic              walk_busy;

  cdl_cfg_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .len       (cfg_len),
    .base      (cfg_base),
    .cfg_err   (cfg_err),
    .last_addr (last_addr)
  );

  cdl_wr_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_err    (cfg_err),
    .len        (cfg_len),
    .base       (cfg_base),
    .last_addr  (last_addr),
    .walk_busy  (walk_busy),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .smp_data   (smp_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .newest_ofs (newest_ofs)
  );

  cdl_rd_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_err    (cfg_err),
    .len        (cfg_len),
    .base       (cfg_base),
    .last_addr  (last_addr),
    .newest_ofs (newest_ofs),
    .pass_start (pass_start),
    .busy       (walk_busy),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .pass_done  (pass_done)
  );

  AST_NO_RW_ON_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_valid)); // R1
endmodule

// File: tb/circ_delay_line_test.sv
module circ_delay_line_test;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic              cfg_err;
  logic              smp_valid = 1'b0;
  logic              smp_ready;
  logic [DATA_W-1:0] smp_data = '0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              pass_start = 1'b0;
  logic              rd_valid;
  logic              rd_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic              pass_done;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_ofs  = 0;
  int cur_n    = 1;
  int cur_base = 0;
  int dcount   = 16'h100;

  always #10 clk = ~clk;

  circ_delay_line #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_base(cfg_base),
    .cfg_err(cfg_err), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pass_start(pass_start), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .pass_done(pass_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_cfg(input int n, input int base);
    cur_n = n;
    cur_base = base;
    exp_ofs = 0;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_len = LEN_W'(n);
    cfg_base = ADDR_W'(base);
    smp_valid = 1'b0;
    pass_start = 1'b0;
    rd_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    #1;
    chk(cfg_err == 1'b0, "R3", "cfg_err aligned", int'(cfg_err), 0);
    chk(smp_ready == 1'b1, "R1", "smp_ready", int'(smp_ready), 1);
    chk(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
  endtask

  task automatic send_sample();
    int d;
    d = dcount;
    dcount++;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = DATA_W'(d);
    #1;
    chk(smp_ready == 1'b1, "R4", "smp_ready idle", int'(smp_ready), 1);
    chk(wr_en == 1'b1, "R4", "wr_en", int'(wr_en), 1);
    chk(int'(wr_addr) == cur_base + exp_ofs, "R2", "wr_addr", int'(wr_addr), cur_base + exp_ofs);
    chk(int'(wr_data) == d, "R4", "wr_data", int'(wr_data), d);
    @(posedge clk);
    exp_ofs = (exp_ofs + 1) % cur_n;
    #1;
    smp_valid = 1'b0;
  endtask

  task automatic run_pass(input int stall_mod, input int inject_at,
                          input bit restart, input bit with_sample);
    int newest;
    int i;
    int cyc;
    bit injected;
    int hold_d;
    int ea;
    i = 0;
    cyc = 0;
    injected = 1'b0;
    hold_d = 0;
    @(negedge clk);
    pass_start = 1'b1;
    if (with_sample) begin
      smp_valid = 1'b1;
      smp_data = DATA_W'(dcount);
    end
    #1;
    if (with_sample) begin
      chk(wr_en == 1'b1, "R5", "write with start", int'(wr_en), 1);
      chk(int'(wr_addr) == cur_base + exp_ofs, "R5", "write addr with start",
          int'(wr_addr), cur_base + exp_ofs);
    end
    @(posedge clk);
    if (with_sample) begin
      exp_ofs = (exp_ofs + 1) % cur_n;
      dcount++;
    end
    #1;
    pass_start = 1'b0;
    smp_valid = 1'b0;
    newest = (exp_ofs + cur_n - 1) % cur_n;
    while (i < cur_n) begin
      @(negedge clk);
      rd_ready = (stall_mod != 0 && (cyc % stall_mod) == 1) ? 1'b0 : 1'b1;
      pass_start = (restart && cyc == 1);
      if (cyc == inject_at) begin
        smp_valid = 1'b1;
        smp_data = DATA_W'(dcount);
        hold_d = dcount;
        dcount++;
      end
      #1;
      ea = cur_base + (newest - i + cur_n) % cur_n;
      chk(rd_valid == 1'b1, "R5", "rd_valid in pass", int'(rd_valid), 1);
      if (rd_ready) begin
        chk(int'(rd_addr) == ea, "R5", "rd_addr", int'(rd_addr), ea);
        chk(pass_done == (i == cur_n - 1), "R6", "pass_done", int'(pass_done),
            int'(i == cur_n - 1));
      end else begin
        chk(int'(rd_addr) == ea, "R7", "rd_addr stalled", int'(rd_addr), ea);
      end
      if (cyc == inject_at) begin
        chk(smp_ready == 1'b1, "R8", "smp_ready before hold", int'(smp_ready), 1);
        chk(wr_en == 1'b0, "R8", "no write in pass", int'(wr_en), 0);
      end else if (injected) begin
        chk(smp_ready == 1'b0, "R8", "smp_ready hold full", int'(smp_ready), 0);
        chk(wr_en == 1'b0, "R8", "no write while held", int'(wr_en), 0);
      end
      @(posedge clk);
      if (cyc == inject_at) injected = 1'b1;
      if (rd_ready) i++;
      cyc++;
      #1;
      smp_valid = 1'b0;
      pass_start = 1'b0;
    end
    @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, restart ? "R9" : "R6", "rd_valid after pass", int'(rd_valid), 0);
    if (injected) begin
      chk(wr_en == 1'b1, "R8", "held write", int'(wr_en), 1);
      chk(int'(wr_addr) == cur_base + exp_ofs, "R8", "held addr", int'(wr_addr),
          cur_base + exp_ofs);
      chk(int'(wr_data) == hold_d, "R8", "held data", int'(wr_data), hold_d);
      @(posedge clk);
      exp_ofs = (exp_ofs + 1) % cur_n;
      @(negedge clk);
      #1;
      chk(smp_ready == 1'b1, "R8", "smp_ready after flush", int'(smp_ready), 1);
    end
  endtask

  task automatic good_cfg(input int n, input int base);
    start_cfg(n, base);
    check_reset_state();
    for (int k = 0; k < n + 2; k++) send_sample();
    run_pass(3, -1, 1'b0, 1'b0);
    run_pass(0, n / 2, (n >= 3), 1'b0);
    run_pass(0, -1, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) send_sample();
    run_pass(4, 0, 1'b0, 1'b0);
  endtask

  task automatic bad_cfg(input int n, input int base);
    start_cfg(n, base);
    @(negedge clk);
    #1;
    chk(cfg_err == 1'b1, "R3", "cfg_err misaligned", int'(cfg_err), 1);
    chk(smp_ready == 1'b0, "R3", "smp_ready on error", int'(smp_ready), 0);
    @(negedge clk);
    smp_valid = 1'b1;
    pass_start = 1'b1;
    #1;
    chk(wr_en == 1'b0, "R3", "wr_en on error", int'(wr_en), 0);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    pass_start = 1'b0;
    @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, "R3", "pass ignored on error", int'(rd_valid), 0);
    chk(wr_en == 1'b0, "R3", "no write after error", int'(wr_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    good_cfg(1, 16'h0040);
    good_cfg(3, 16'h0104);   // R10 odd length
    good_cfg(5, 16'h0208);   // R10
    good_cfg(8, 16'h0310);
    good_cfg(12, 16'h0400);  // R10
    good_cfg(30, 16'h0a20);  // R3 five zero bits suffice
    good_cfg(32, 16'h0b40);  // R3 six zero bits
    good_cfg(200, 16'h2100); // R10
    bad_cfg(0, 16'h0000);
    bad_cfg(3, 16'h0101);
    bad_cfg(30, 16'h0a10);
    bad_cfg(32, 16'h0b20);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule